// File: doc/BRIEF.md
# Local-History Branch Direction Predictor

This block guesses whether a conditional branch will be taken, using the branch's own recent outcomes. A fetch-side lookup presents a branch address and receives a taken or not-taken guess combinationally, in the same cycle. An execute-side port reports each resolved branch, with its address and real outcome. That report advances the branch's outcome history and trains a 2-bit confidence counter.

Storage is split across two tables. The first table holds one short shift register of outcomes per branch slot, selected by low address bits. That history, joined with a few more address bits, selects one saturating counter in the second table. The counter's upper bit is the guess. Because the counter is chosen by the outcome pattern, a repeating sequence such as a three-iteration loop becomes fully predictable once the counters are trained.

Top module: `localBranchPredictor`

## Requirements
- R1: After reset every counter holds 01 and every history holds zero, so every address predicts not taken until an update arrives.
- R2: A resolved taken outcome raises the selected counter by one and a not-taken outcome lowers it by one. The counter holds at 11 on a taken outcome and at 00 on a not-taken outcome.
- R3: The guess `predTaken` is 1 exactly when the selected counter is 10 or 11. Encoding: 00 strong not-taken, 01 weak not-taken, 10 weak taken, 11 strong taken.
- R4: A counter at 11 that sees one not-taken outcome moves to 10 and still predicts taken.
- R5: The history table has 2^BHT_K slots selected by address bits [BHT_K+1:2]. Addresses that agree in those bits share one history.
- R6: On an update, the selected history shifts left by one. The outcome enters bit 0 (1 = taken) and the oldest bit is dropped.
- R7: The counter index is {history, address bits [PHT_P+1:2]}, with the history in the upper bits. Two branches whose histories are equal but whose low address bits differ use different counters.
- R8: A branch repeating taken, taken, taken, not-taken is predicted correctly on every occurrence once warmed up. History 111 predicts not taken and history 110 predicts taken.
- R9: The guess depends only on the current table contents. When an update targets the same entry in the same cycle, the guess reflects the contents before that update, and the update is visible from the next cycle.
- R10: While `updValid` is low, neither table changes, whatever `updPc` and `updTaken` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| predPc | input | PC_W | Address of the branch being looked up |
| predTaken | output | 1 | Combinational guess for `predPc`, 1 = taken |
| updValid | input | 1 | A resolved branch is reported this cycle |
| updPc | input | PC_W | Address of the resolved branch |
| updTaken | input | 1 | Resolved outcome, 1 = taken |

## Verification
The bench builds the predictor with a 3-bit history, 16 history slots and 2 address bits in the counter index. This gives 32 counters, which is small enough to follow exactly. With a 3-bit history, a period-4 loop pattern gives four distinct histories, so the bench can check the exit prediction directly. With only 16 slots, addresses 0x100 and 0x140 collide, so history sharing between branches can be observed at the ports. A long pseudo-random run over eight branches checks every guess against a shadow table built from the rules above, and it reaches both saturation limits many times.

// File: rtl/lapPkg.sv
package lapPkg;

  // Counter encodings; the prediction is the upper bit.
  localparam logic [1:0] CNT_SNT = 2'b00;
  localparam logic [1:0] CNT_WNT = 2'b01;
  localparam logic [1:0] CNT_WT  = 2'b10;
  localparam logic [1:0] CNT_ST  = 2'b11;
  localparam logic [1:0] CNT_INIT = CNT_WNT;

  // Strobes from control to datapath.
  typedef struct packed {
    logic histWe;  // shift the outcome into the selected history
    logic cntWe;   // write the selected counter
    logic cntUp;   // 1: step up, 0: step down
  } lapStrobe_t;

endpackage

// File: rtl/lapCtrl.sv
module lapCtrl
  import lapPkg::*;
(
  input  logic       updValid,
  input  logic       updTaken,
  input  logic [1:0] updCnt,
  output lapStrobe_t strobe
);

  logic atTop;
  logic atBottom;

  assign atTop    = (updCnt == CNT_ST);
  assign atBottom = (updCnt == CNT_SNT);

  // Counter writes are suppressed at the saturation limits.
  always_comb begin
    strobe.histWe = updValid;
    strobe.cntUp  = updTaken;
    strobe.cntWe  = updValid && (updTaken ? !atTop : !atBottom);
  end

endmodule

// File: rtl/lapData.sv
module lapData
  import lapPkg::*;
#(
  parameter int PC_W   = 32,
  parameter int HIST_W = 3,
  parameter int BHT_K  = 4,
  parameter int PHT_P  = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  lapStrobe_t               strobe,
  input  logic [PC_W-1:0]          predPc,
  input  logic [PC_W-1:0]          updPc,
  input  logic                     updTaken,
  output logic [1:0]               predCnt,
  output logic [HIST_W-1:0]        updHist,
  output logic [1:0]               updCnt,
  output logic [HIST_W+PHT_P-1:0]  updPhtIdx
);

  localparam int BHT_N = 1 << BHT_K;
  localparam int PHT_W = HIST_W + PHT_P;
  localparam int PHT_N = 1 << PHT_W;

  logic [HIST_W-1:0] bhtMem [BHT_N];
  logic [1:0]        phtMem [PHT_N];

  logic [BHT_K-1:0]  predBhtIdx;
  logic [BHT_K-1:0]  updBhtIdx;
  logic [HIST_W-1:0] predHist;
  logic [PHT_W-1:0]  predPhtIdx;
  logic [HIST_W-1:0] histNext;

  assign predBhtIdx = predPc[BHT_K+1:2];
  assign updBhtIdx  = updPc[BHT_K+1:2];
  assign predHist   = bhtMem[predBhtIdx];
  assign updHist    = bhtMem[updBhtIdx];

  // Counter index: history in the upper bits, optional address bits below.
  generate
    if (PHT_P > 0) begin : g_pcBits
      assign predPhtIdx = {predHist, predPc[PHT_P+1:2]};
      assign updPhtIdx  = {updHist, updPc[PHT_P+1:2]};
    end else begin : g_histOnly
      assign predPhtIdx = predHist;
      assign updPhtIdx  = updHist;
    end
  endgenerate

  // History shift: newest outcome in bit 0.
  generate
    if (HIST_W > 1) begin : g_shift
      assign histNext = {updHist[HIST_W-2:0], updTaken};
    end else begin : g_single
      assign histNext = updTaken;
    end
  endgenerate

  assign predCnt = phtMem[predPhtIdx];
  assign updCnt  = phtMem[updPhtIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < BHT_N; i++) bhtMem[i] <= '0;
    end else if (strobe.histWe) begin
      bhtMem[updBhtIdx] <= histNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < PHT_N; i++) phtMem[i] <= CNT_INIT;
    end else if (strobe.cntWe) begin
      phtMem[updPhtIdx] <= strobe.cntUp ? updCnt + 2'd1 : updCnt - 2'd1;
    end
  end

endmodule

// File: rtl/localBranchPredictor.sv
module localBranchPredictor
  import lapPkg::*;
#(
  parameter int PC_W   = 32,
  parameter int HIST_W = 3,
  parameter int BHT_K  = 4,
  parameter int PHT_P  = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PC_W-1:0] predPc,
  output logic            predTaken,
  input  logic            updValid,
  input  logic [PC_W-1:0] updPc,
  input  logic            updTaken
);

  localparam int PHT_W = HIST_W + PHT_P;

  lapStrobe_t        strobe;
  logic [1:0]        predCnt;
  logic [1:0]        updCnt;
  logic [HIST_W-1:0] updHist;
  logic [PHT_W-1:0]  updPhtIdx;

  lapCtrl i_ctrl (
    .updValid (updValid),
    .updTaken (updTaken),
    .updCnt   (updCnt),
    .strobe   (strobe)
  );

  lapData #(
    .PC_W   (PC_W),
    .HIST_W (HIST_W),
    .BHT_K  (BHT_K),
    .PHT_P  (PHT_P)
  ) i_data (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .predPc    (predPc),
    .updPc     (updPc),
    .updTaken  (updTaken),
    .predCnt   (predCnt),
    .updHist   (updHist),
    .updCnt    (updCnt),
    .updPhtIdx (updPhtIdx)
  );

  assign predTaken = predCnt[1];

endmodule

// File: rtl/lapChecker.sv
module lapChecker #(
  parameter int PC_W   = 32,
  parameter int HIST_W = 3,
  parameter int PHT_P  = 2
) (
  input logic                    clk,
  input logic                    rstN,
  input logic [PC_W-1:0]         predPc,
  input logic                    predTaken,
  input logic                    updValid,
  input logic [PC_W-1:0]         updPc,
  input logic                    updTaken,
  input logic [HIST_W-1:0]       updHist,
  input logic [1:0]              updCnt,
  input logic [HIST_W+PHT_P-1:0] updPhtIdx
);

  // Set once a full cycle out of reset has passed, so $past is valid.
  logic armed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  // R1: nothing is predicted taken on the first cycle out of reset.
  p_reset_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !predTaken);

  // R2 and R4: back-to-back updates to one counter step it with saturation.
  p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (armed && updValid && $past(updValid) && updPhtIdx == $past(updPhtIdx))
    |-> updCnt == ($past(updTaken)
                   ? (($past(updCnt) == 2'b11) ? 2'b11 : $past(updCnt) + 2'd1)
                   : (($past(updCnt) == 2'b00) ? 2'b00 : $past(updCnt) - 2'd1)));

  // R6: back-to-back updates of one branch show the shifted history.
  generate
    if (HIST_W > 1) begin : g_histChk
      p_hist_shift_r6: assert property (@(posedge clk) disable iff (!rstN)
        (armed && updValid && $past(updValid) && updPc == $past(updPc))
        |-> updHist == {$past(updHist[HIST_W-2:0]), $past(updTaken)});
    end
  endgenerate

  // R9: a same-cycle lookup of the branch being updated sees the old counter.
  p_pre_update_r9: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && predPc == updPc) |-> predTaken == updCnt[1]);

  // R10: without an update the guess for a fixed address is unchanged.
  p_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !updValid |=> ($stable(predPc) -> $stable(predTaken)));

endmodule

bind localBranchPredictor lapChecker #(
  .PC_W   (PC_W),
  .HIST_W (HIST_W),
  .PHT_P  (PHT_P)
) i_lapChecker (
  .clk       (clk),
  .rstN      (rstN),
  .predPc    (predPc),
  .predTaken (predTaken),
  .updValid  (updValid),
  .updPc     (updPc),
  .updTaken  (updTaken),
  .updHist   (updHist),
  .updCnt    (updCnt),
  .updPhtIdx (updPhtIdx)
);

// File: tb/test_localBranchPredictor.sv
module test_localBranchPredictor;

  localparam int CLK_PERIOD = 10;
  localparam int PC_W   = 32;
  localparam int HIST_W = 3;
  localparam int BHT_K  = 4;
  localparam int PHT_P  = 2;
  localparam int BHT_N  = 1 << BHT_K;
  localparam int PHT_N  = 1 << (HIST_W + PHT_P);

  logic            clk = 1'b0;
  logic            rstN;
  logic [PC_W-1:0] predPc;
  logic            predTaken;
  logic            updValid;
  logic [PC_W-1:0] updPc;
  logic            updTaken;

  int nTests = 0;
  int nFails = 0;
  bit done   = 1'b0;

  // Shadow tables built from the requirements.
  logic [HIST_W-1:0] mHist [BHT_N];
  logic [1:0]        mCnt  [PHT_N];

  always #(CLK_PERIOD / 2) clk = ~clk;

  localBranchPredictor #(
    .PC_W (PC_W), .HIST_W (HIST_W), .BHT_K (BHT_K), .PHT_P (PHT_P)
  ) i_localBranchPredictor (
    .clk (clk), .rstN (rstN), .predPc (predPc), .predTaken (predTaken),
    .updValid (updValid), .updPc (updPc), .updTaken (updTaken)
  );

  function automatic int mIdx(input logic [PC_W-1:0] pc);
    return int'({mHist[pc[BHT_K+1:2]], pc[PHT_P+1:2]});
  endfunction

  function automatic logic mPred(input logic [PC_W-1:0] pc);
    return mCnt[mIdx(pc)][1];
  endfunction

  task automatic mUpdate(input logic [PC_W-1:0] pc, input logic t);
    int ci = mIdx(pc);
    if (t && mCnt[ci] != 2'b11) mCnt[ci] = mCnt[ci] + 2'd1;
    if (!t && mCnt[ci] != 2'b00) mCnt[ci] = mCnt[ci] - 2'd1;
    mHist[pc[BHT_K+1:2]] = {mHist[pc[BHT_K+1:2]][HIST_W-2:0], t};
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    nTests++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: predTaken=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // One resolved branch; the guess for the same address is checked before the edge.
  task automatic step(input logic [PC_W-1:0] pc, input logic t, input string tag);
    @(negedge clk);
    predPc = pc; updValid = 1'b1; updPc = pc; updTaken = t;
    #1;
    chk(tag, predTaken, mPred(pc));
    @(posedge clk);
    mUpdate(pc, t);
  endtask

  // Lookup without an update.
  task automatic peek(input logic [PC_W-1:0] pc, output logic r);
    @(negedge clk);
    updValid = 1'b0; predPc = pc;
    #1;
    r = predTaken;
  endtask

  task automatic testReset();
    logic r;
    for (int i = 0; i < BHT_N; i++) mHist[i] = '0;
    for (int i = 0; i < PHT_N; i++) mCnt[i] = 2'b01;
    rstN = 1'b0; updValid = 1'b0; updPc = '0; updTaken = 1'b0; predPc = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    for (int i = 0; i < 4; i++) begin
      peek(32'h100 + 32'(i * 36), r);
      chk("R1 reset predicts not taken", r, 1'b0);
    end
  endtask

  task automatic testSaturate();
    logic r;
    for (int i = 0; i < 6; i++) step(32'h100, 1'b1, "R3 taken training");
    peek(32'h100, r);
    chk("R2 history 111 counter saturated taken", r, 1'b1);
    step(32'h100, 1'b0, "R2 single not-taken");
    for (int i = 0; i < 3; i++) step(32'h100, 1'b1, "R6 rebuild history");
    peek(32'h100, r);
    chk("R4 strong taken survives one not-taken", r, 1'b1);
  endtask

  task automatic testLoop();
    logic pat [4] = '{1'b1, 1'b1, 1'b1, 1'b0};
    logic r;
    for (int p = 0; p < 5; p++)
      for (int s = 0; s < 4; s++) step(32'h20C, pat[s], "R8 loop warm-up");
    for (int p = 0; p < 3; p++)
      for (int s = 0; s < 4; s++) begin
        peek(32'h20C, r);
        chk("R8 loop outcome predicted", r, pat[s]);
        step(32'h20C, pat[s], "R8 loop step");
      end
  endtask

  task automatic testAlias();
    logic r;
    peek(32'h140, r);
    chk("R5 shared slot inherits history 111", r, 1'b1);
    peek(32'h104, r);
    chk("R5 distinct slot stays untrained", r, 1'b0);
    for (int i = 0; i < 3; i++) step(32'h104, 1'b1, "R7 train other branch");
    peek(32'h104, r);
    chk("R7 same history other address bits uses own counter", r, 1'b0);
  endtask

  task automatic testSameCycle();
    logic r;
    @(negedge clk);
    predPc = 32'h110; updValid = 1'b1; updPc = 32'h110; updTaken = 1'b0;
    #1;
    chk("R9 same-cycle guess uses old counter", predTaken, 1'b1);
    @(posedge clk);
    mUpdate(32'h110, 1'b0);
    peek(32'h110, r);
    chk("R9 update visible next cycle", r, 1'b0);
  endtask

  task automatic testNoUpdate();
    logic r;
    @(negedge clk);
    updValid = 1'b0; updPc = 32'h110; updTaken = 1'b1; predPc = 32'h110;
    repeat (4) @(posedge clk);
    @(negedge clk) updTaken = 1'b0; updPc = 32'h100;
    repeat (4) @(posedge clk);
    peek(32'h110, r);
    chk("R10 idle port leaves 0x110 untouched", r, 1'b0);
    peek(32'h100, r);
    chk("R10 idle port leaves 0x100 untouched", r, 1'b1);
  endtask

  task automatic testRandom();
    logic [15:0] lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(32'h300 + {27'd0, lfsr[2:0], 2'b00}, lfsr[5] | lfsr[9],
           "R2 R6 R7 random stream");
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      nTests++;
      nFails++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFails);
      $finish;
    end
  end

  initial begin
    testReset();
    testSaturate();
    testLoop();
    testAlias();
    testSameCycle();
    testNoUpdate();
    testRandom();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

endmodule